// File: doc/BRIEF.md
# Timed Quantum Microinstruction Issuer

This block takes a stream of quantum microinstructions and turns it into entries for a downstream event timing controller. That controller owns the deterministic clock. The issuer itself has no notion of real time. It decodes each instruction as soon as it arrives and converts it into queue writes. A delay instruction becomes a time-point entry. Every operation becomes an event entry stamped with a label, and downstream logic uses the label to rebuild the timeline.

A 4-bit label register sets the stamp. A delay instruction writes its interval, together with the label currently open, into the timing queue, and then moves the label on by one. Pulse, measurement-pulse and discrimination instructions write events stamped with the open label, so all operations issued between two delays fire at the same time point. A pulse instruction carries several qubit/operation slots and is expanded into one event per occupied slot. When a queue reports full, the issuer holds the instruction until space appears. An instruction with an unrecognised opcode is dropped and a one-cycle error strobe is raised.

Instruction word (32 bits): opcode in bits [31:29]. Opcode 0 is delay, with the interval in [15:0]. Opcode 1 is pulse, with slot k in bits [8k+7:8k] for k = 0..2; each slot holds a qubit address in its upper 3 bits and an operation code in its lower 5 bits. Opcode 2 is measurement pulse, with the qubit address in [18:16] and the duration in [15:0]. Opcode 3 is discriminate, with the qubit address in [18:16] and the destination register in [4:0]. Opcodes 4 to 7 are undefined.

Top module: `qi_issuer`

## Requirements
- R1: After reset `in_ready` is 1, both push strobes and `err` are 0, and the first delay is stamped with label 0.
- R2: A delay instruction produces exactly one timing-queue push carrying interval = bits [15:0] and the open label; the label seen after that push is one higher.
- R3: The label wraps modulo 16, so the seventeenth delay after any point carries the same label as the first.
- R4: Every event pushed between two delay pushes carries the label of the later delay's push, i.e. the label still open when the event is issued.
- R5: A pulse instruction pushes one event per slot whose operation code is non-zero, in ascending slot order, with kind 1, the slot's qubit address, and arg = operation code. Slots with code 0 produce nothing, and an all-empty pulse produces no push.
- R6: A measurement-pulse instruction pushes one event with kind 2, qubit address [18:16] and arg = duration [15:0].
- R7: A discriminate instruction pushes one event with kind 3, qubit address [18:16] and arg = register index [4:0].
- R8: While a queue's full input is 1, no push to that queue occurs and `in_ready` stays 0 for an instruction waiting on it. The instruction is issued once full falls, and none is lost.
- R9: An undefined opcode (bit 31 set) raises `err` for exactly one cycle, produces no push and leaves the label unchanged.
- R10: At most one of the two push strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction taken at this edge when in_valid is 1 |
| in_instr | input | 32 | Instruction word |
| tq_full | input | 1 | Timing queue cannot accept a push |
| tq_push | output | 1 | Timing-queue write strobe |
| tq_interval | output | 16 | Interval of the time point |
| tq_label | output | 4 | Label of the time point |
| eq_full | input | 1 | Event queue cannot accept a push |
| eq_push | output | 1 | Event-queue write strobe |
| eq_kind | output | 2 | 1 pulse, 2 measurement pulse, 3 discriminate |
| eq_qaddr | output | 3 | Target qubit address |
| eq_arg | output | 16 | Operation code, duration or register index |
| eq_label | output | 4 | Label the event is tied to |
| err | output | 1 | One-cycle strobe for an undefined opcode |

## Verification
The checks assume that both full inputs behave like real queue flags. Full only changes between clock edges and is never raised in response to a push in the same cycle. The bench changes full only on the falling edge. The label-step property also assumes the label register is touched only by delay pushes. For that reason the bench follows every undefined opcode with a delay whose label it compares with the one before. The bench holds `in_valid` with a stable word until the word is taken, which matches the assumption that the word is not withdrawn while it waits.

// File: rtl/qi_pkg.sv
package qi_pkg;
  localparam logic [2:0] OPC_WAIT  = 3'd0;
  localparam logic [2:0] OPC_PULSE = 3'd1;
  localparam logic [2:0] OPC_MPG   = 3'd2;
  localparam logic [2:0] OPC_MD    = 3'd3;

  localparam logic [1:0] EVK_PULSE = 2'd1;
  localparam logic [1:0] EVK_MPG   = 2'd2;
  localparam logic [1:0] EVK_MD    = 2'd3;

  localparam int OPC_W = 3;
endpackage

// File: rtl/qi_decode.sv
module qi_decode #(
  parameter int IW    = 32,
  parameter int QA_W  = 3,
  parameter int UOP_W = 5,
  parameter int NPAIR = 3,
  parameter int ARG_W = 16,
  parameter int RD_W  = 5
) (
  input  logic [IW-1:0]          instr,
  output logic [2:0]             opc,
  output logic                   known,
  output logic [NPAIR-1:0]       slot_live,
  output logic [NPAIR*QA_W-1:0]  slot_q,
  output logic [NPAIR*UOP_W-1:0] slot_u,
  output logic [QA_W-1:0]        qaddr,
  output logic [ARG_W-1:0]       imm,
  output logic [RD_W-1:0]        rd
);
  import qi_pkg::*;
  localparam int SLOT_W = QA_W + UOP_W;

  assign opc   = instr[IW-1 -: OPC_W];
  assign known = (opc == OPC_WAIT) || (opc == OPC_PULSE) ||
                 (opc == OPC_MPG)  || (opc == OPC_MD);
  assign qaddr = instr[ARG_W +: QA_W];
  assign imm   = instr[ARG_W-1:0];
  assign rd    = instr[RD_W-1:0];

  for (genvar g = 0; g < NPAIR; g++) begin : g_slot
    assign slot_u[g*UOP_W +: UOP_W] = instr[g*SLOT_W +: UOP_W];
    assign slot_q[g*QA_W +: QA_W]   = instr[g*SLOT_W+UOP_W +: QA_W];
    assign slot_live[g]             = |instr[g*SLOT_W +: UOP_W];
  end
endmodule

// File: rtl/qi_pick.sv
module qi_pick #(
  parameter int N = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/qi_label.sv
module qi_label #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (step) q <= q + 1'b1;
  end
endmodule

// File: rtl/qi_issuer.sv
module qi_issuer #(
  parameter int IW    = 32,
  parameter int LBL_W = 4,
  parameter int QA_W  = 3,
  parameter int UOP_W = 5,
  parameter int NPAIR = 3,
  parameter int ARG_W = 16,
  parameter int RD_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IW-1:0]    in_instr,
  input  logic             tq_full,
  output logic             tq_push,
  output logic [ARG_W-1:0] tq_interval,
  output logic [LBL_W-1:0] tq_label,
  input  logic             eq_full,
  output logic             eq_push,
  output logic [1:0]       eq_kind,
  output logic [QA_W-1:0]  eq_qaddr,
  output logic [ARG_W-1:0] eq_arg,
  output logic [LBL_W-1:0] eq_label,
  output logic             err
);
  import qi_pkg::*;
  localparam int SLOT_W = QA_W + UOP_W;
  localparam int IDX_W  = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic                   busy;
  logic [IW-1:0]          cur;
  logic [NPAIR-1:0]       pend;
  logic                   err_q;
  logic [LBL_W-1:0]       lbl_q;

  logic [2:0]             opc;
  logic                   known;
  logic [NPAIR-1:0]       cur_live;
  logic [NPAIR*QA_W-1:0]  slot_q;
  logic [NPAIR*UOP_W-1:0] slot_u;
  logic [QA_W-1:0]        qaddr;
  logic [ARG_W-1:0]       imm;
  logic [RD_W-1:0]        rd;
  logic [NPAIR-1:0]       nxt_onehot;
  logic [IDX_W-1:0]       nxt_idx;
  logic [NPAIR-1:0]       in_live;
  logic                   ev_want;
  logic                   done;
  logic                   accept;

  qi_decode #(.IW(IW), .QA_W(QA_W), .UOP_W(UOP_W), .NPAIR(NPAIR),
              .ARG_W(ARG_W), .RD_W(RD_W)) u_dec (
    .instr(cur), .opc(opc), .known(known), .slot_live(cur_live),
    .slot_q(slot_q), .slot_u(slot_u), .qaddr(qaddr), .imm(imm), .rd(rd)
  );

  qi_pick #(.N(NPAIR)) u_pick (
    .req(pend), .onehot(nxt_onehot), .idx(nxt_idx)
  );

  qi_label #(.W(LBL_W)) u_lbl (
    .clk(clk), .rst(rst), .step(tq_push), .q(lbl_q)
  );

  // occupied-slot mask of the word on the input, loaded on acceptance
  for (genvar g = 0; g < NPAIR; g++) begin : g_inlive
    assign in_live[g] = |in_instr[g*SLOT_W +: UOP_W];
  end

  always_comb begin
    tq_push = busy && (opc == OPC_WAIT) && !tq_full;
    ev_want = busy && (((opc == OPC_PULSE) && (|pend)) ||
                       (opc == OPC_MPG) || (opc == OPC_MD));
    eq_push = ev_want && !eq_full;

    unique case (opc)
      OPC_WAIT:  done = tq_push;
      OPC_PULSE: done = (pend == '0) ||
                        (eq_push && ((pend & ~nxt_onehot) == '0));
      OPC_MPG,
      OPC_MD:    done = eq_push;
      default:   done = 1'b1;
    endcase
    done = done && busy;

    in_ready = !busy || done;
    accept   = in_valid && in_ready;

    tq_interval = imm;
    tq_label    = lbl_q;
    eq_label    = lbl_q;

    eq_kind  = EVK_PULSE;
    eq_qaddr = qaddr;
    eq_arg   = imm;
    unique case (opc)
      OPC_PULSE: begin
        eq_kind  = EVK_PULSE;
        eq_qaddr = slot_q[nxt_idx*QA_W +: QA_W];
        eq_arg   = ARG_W'(slot_u[nxt_idx*UOP_W +: UOP_W]);
      end
      OPC_MPG: eq_kind = EVK_MPG;
      OPC_MD: begin
        eq_kind = EVK_MD;
        eq_arg  = ARG_W'(rd);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cur   <= '0;
      pend  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= busy && !known;
      if (accept) begin
        busy <= 1'b1;
        cur  <= in_instr;
        pend <= (in_instr[IW-1 -: OPC_W] == OPC_PULSE) ? in_live : '0;
      end else begin
        if (done)    busy <= 1'b0;
        if (eq_push) pend <= pend & ~nxt_onehot;
      end
    end
  end

  assign err = err_q;
endmodule

// File: rtl/qi_issuer_chk.sv
module qi_issuer_chk #(
  parameter int LBL_W = 4,
  parameter int ARG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tq_push,
  input logic             tq_full,
  input logic [LBL_W-1:0] tq_label,
  input logic             eq_push,
  input logic             eq_full,
  input logic [1:0]       eq_kind,
  input logic [ARG_W-1:0] eq_arg,
  input logic [LBL_W-1:0] lbl_q
);
  // R8
  no_tq_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    tq_full |-> !tq_push);

  // R8
  no_eq_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    eq_full |-> !eq_push);

  // R10
  one_push_chk: assert property (@(posedge clk) disable iff (rst)
    !(tq_push && eq_push));

  // R2
  label_step_chk: assert property (@(posedge clk) disable iff (rst)
    tq_push |=> (lbl_q == $past(tq_label) + 1'b1));

  // R3
  label_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tq_push && (&tq_label)) |=> (lbl_q == '0));

  // R5
  no_empty_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (eq_push && (eq_kind == 2'd1)) |-> (eq_arg != '0));
endmodule

bind qi_issuer qi_issuer_chk #(.LBL_W(LBL_W), .ARG_W(ARG_W)) u_chk (
  .clk(clk), .rst(rst), .tq_push(tq_push), .tq_full(tq_full),
  .tq_label(tq_label), .eq_push(eq_push), .eq_full(eq_full),
  .eq_kind(eq_kind), .eq_arg(eq_arg), .lbl_q(lbl_q)
);

// File: tb/sim_qi_issuer.sv
`timescale 1ns/1ps
module sim_qi_issuer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        tq_full = 1'b0;
  logic        tq_push;
  logic [15:0] tq_interval;
  logic [3:0]  tq_label;
  logic        eq_full = 1'b0;
  logic        eq_push;
  logic [1:0]  eq_kind;
  logic [2:0]  eq_qaddr;
  logic [15:0] eq_arg;
  logic [3:0]  eq_label;
  logic        err;

  always #4 clk = ~clk;

  qi_issuer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .tq_full(tq_full), .tq_push(tq_push),
    .tq_interval(tq_interval), .tq_label(tq_label), .eq_full(eq_full),
    .eq_push(eq_push), .eq_kind(eq_kind), .eq_qaddr(eq_qaddr),
    .eq_arg(eq_arg), .eq_label(eq_label), .err(err)
  );

  int checks = 0;
  int errors = 0;

  // expected push list, built from the requirements
  logic        x_tq   [64];
  logic [1:0]  x_kind [64];
  logic [2:0]  x_q    [64];
  logic [15:0] x_arg  [64];
  logic [3:0]  x_lbl  [64];
  int          x_n = 0;
  int          o_n = 0;
  logic [3:0]  lbl_m = 4'd0;
  int          x_err = 0;
  int          err_seen = 0;
  logic [3:0]  last_tq_lbl = 4'd0;

  localparam logic [31:0] VEC [12] = '{
    32'h0000_0004,  // delay 4
    32'h2000_4723,  // pulse: slot0 q1 op3, slot1 q2 op7
    32'h4005_012C,  // measurement pulse q5, 300 cycles
    32'h0000_000A,  // delay 10
    32'h6005_0009,  // discriminate q5 -> reg 9
    32'h2062_FF01,  // pulse: three slots
    32'h2000_0000,  // pulse, all slots empty
    32'h0000_0000,  // delay 0
    32'h20C4_0000,  // pulse: only slot2 q6 op4
    32'h0000_FFFF,  // delay max
    32'h6000_001F,  // discriminate q0 -> reg 31
    32'h4007_0001   // measurement pulse q7, 1 cycle
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_x(input logic t, input logic [1:0] k, input logic [2:0] q,
                        input logic [15:0] a, input logic [3:0] l);
    x_tq[x_n] = t; x_kind[x_n] = k; x_q[x_n] = q; x_arg[x_n] = a; x_lbl[x_n] = l;
    x_n++;
  endtask

  task automatic model(input logic [31:0] w);
    case (w[31:29])
      3'd0: begin push_x(1'b1, 2'd0, 3'd0, w[15:0], lbl_m); lbl_m = lbl_m + 4'd1; end
      3'd1: for (int i = 0; i < 3; i++)
              if (w[i*8 +: 5] != 5'd0)
                push_x(1'b0, 2'd1, w[i*8+5 +: 3], {11'd0, w[i*8 +: 5]}, lbl_m);
      3'd2: push_x(1'b0, 2'd2, w[18:16], w[15:0], lbl_m);
      3'd3: push_x(1'b0, 2'd3, w[18:16], {11'd0, w[4:0]}, lbl_m);
      default: x_err++;
    endcase
  endtask

  task automatic send(input logic [31:0] w);
    bit rdy;
    model(w);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = w;
    forever begin
      #1 rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: sample just before the rising edge that takes the push
  always begin
    @(negedge clk);
    #2;
    if (!rst) begin
      if (err) err_seen++;
      if (tq_push) begin
        last_tq_lbl = tq_label;
        if (o_n >= x_n || !x_tq[o_n]) begin
          check(1'b0, "R2", "unexpected timing push", tq_interval, 0);
        end else begin
          check(tq_interval == x_arg[o_n], "R2", "interval", tq_interval, x_arg[o_n]);
          check(tq_label == x_lbl[o_n], "R2", "time-point label", tq_label, x_lbl[o_n]);
        end
        o_n++;
      end
      if (eq_push) begin
        if (o_n >= x_n || x_tq[o_n]) begin
          check(1'b0, "R5", "unexpected event push", eq_arg, 0);
        end else begin
          case (x_kind[o_n])
            2'd1: begin
              check(eq_kind == 2'd1, "R5", "kind", eq_kind, 1);
              check(eq_qaddr == x_q[o_n], "R5", "qubit", eq_qaddr, x_q[o_n]);
              check(eq_arg == x_arg[o_n], "R5", "op code", eq_arg, x_arg[o_n]);
            end
            2'd2: begin
              check(eq_kind == 2'd2, "R6", "kind", eq_kind, 2);
              check(eq_qaddr == x_q[o_n], "R6", "qubit", eq_qaddr, x_q[o_n]);
              check(eq_arg == x_arg[o_n], "R6", "duration", eq_arg, x_arg[o_n]);
            end
            default: begin
              check(eq_kind == 2'd3, "R7", "kind", eq_kind, 3);
              check(eq_qaddr == x_q[o_n], "R7", "qubit", eq_qaddr, x_q[o_n]);
              check(eq_arg == x_arg[o_n], "R7", "register", eq_arg, x_arg[o_n]);
            end
          endcase
          check(eq_label == x_lbl[o_n], "R4", "event label", eq_label, x_lbl[o_n]);
        end
        o_n++;
      end
      check(!(tq_push && eq_push), "R10", "dual push", 1, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] pre;
    int e0;
    cycles(3);
    rst = 1'b0;
    #2;
    // R1: state right after reset release
    check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    check(tq_push == 1'b0, "R1", "tq_push", tq_push, 0);
    check(eq_push == 1'b0, "R1", "eq_push", eq_push, 0);
    check(err == 1'b0, "R1", "err", err, 0);

    // table walk; the first delay must carry label 0 (R1)
    foreach (VEC[i]) send(VEC[i]);
    cycles(4);
    check(o_n == x_n, "R5", "push count after table", o_n, x_n);

    // R8: timing queue full holds a delay
    tq_full = 1'b1;
    send(32'h0000_0007);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2;
      check(!tq_push, "R8", "push while timing queue full", tq_push, 0);
      check(!in_ready, "R8", "in_ready while stalled", in_ready, 0);
    end
    @(negedge clk); tq_full = 1'b0;
    cycles(3);
    check(o_n == x_n, "R8", "stalled delay issued", o_n, x_n);

    // R8: event queue full holds a three-slot pulse
    eq_full = 1'b1;
    send(32'h2062_FF01);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      check(!eq_push, "R8", "push while event queue full", eq_push, 0);
    end
    @(negedge clk); eq_full = 1'b0;
    cycles(5);
    check(o_n == x_n, "R8", "stalled pulse slots issued", o_n, x_n);

    // R9: undefined opcodes skipped, label untouched
    pre = lbl_m;
    e0 = err_seen;
    send(32'hE000_1234);
    send(32'h8000_0000);
    cycles(4);
    check(err_seen - e0 == 2, "R9", "error strobe cycles", err_seen - e0, 2);
    check(o_n == x_n, "R9", "no push from undefined opcode", o_n, x_n);
    send(32'h0000_0003);
    cycles(3);
    check(last_tq_lbl == pre, "R9", "label after undefined", last_tq_lbl, pre);

    // R3: sixteen delays bring the label back
    pre = lbl_m;
    for (int i = 0; i < 16; i++) send(32'h0000_0001 + i);
    send(32'h0000_0020);
    cycles(3);
    check(last_tq_lbl == pre, "R3", "label after wrap", last_tq_lbl, pre);
    check(o_n == x_n, "R3", "push count after wrap", o_n, x_n);
    check(err_seen == x_err, "R9", "total error strobes", err_seen, x_err);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule